// File: doc/BRIEF.md
# Sharer Tracking and Acknowledgement Count Unit

This block holds the coherence bookkeeping of one cache line in an inclusive shared cache: a bit vector with one bit per private L1 that may hold the line, plus the ID of the L1 that most recently took the line exclusive. An incoming L1 request is described by its kind and the requester ID. In the same cycle the block returns three results. The first is the refined event class. The second is the mask of L1s that must be sent invalidations. The third is the signed acknowledgement count that the reply to the requester carries.

The reclassification depends on whether the requester is in the sharer set. An upgrade from a non-sharer becomes an exclusive read, and a writeback from a non-sharer is stale but is still acknowledged. The acknowledgement count is a negative number of sharers. It is raised by one when the requester is itself a sharer, because no L1 acknowledges its own invalidation.

Sharer updates arrive on a separate port, one per cycle, and take effect at the next clock edge. The block does not carry messages or line data.

Top module: `sharer_ack_unit`

## Requirements
- R1: After reset the sharer vector is all zero, the owner is 0 and the sharer count is 0.
- R2: A request of kind 2 (upgrade) gives event 2 (upgrade) when the requester bit is set in the sharer vector. Otherwise it gives event 1 (exclusive read) and is handled as one.
- R3: A request of kind 3 (writeback) gives event 3 when the requester is a sharer and event 4 (stale writeback) when it is not. In both cases wb_ack_o is 1, and for every other event wb_ack_o is 0.
- R4: For event 1 (exclusive read), ack_cnt_o equals minus the sharer count, plus one if the requester is a sharer.
- R5: For event 2 (upgrade), ack_cnt_o equals minus the sharer count plus one.
- R6: For events 1 and 2, inv_mask_o equals the sharer vector with the requester bit cleared.
- R7: A request of kind 4 (eviction) gives event 5, inv_mask_o equal to the full sharer vector, and ack_cnt_o of 0.
- R8: Update op 4 (mark exclusive) makes the sharer vector contain only upd_id_i and sets the owner to upd_id_i at the next edge.
- R9: Update op 1 sets the bit of upd_id_i, op 2 clears it and op 3 clears the whole vector, each at the next edge. Op 0 changes nothing, and ops 1 to 3 leave the owner unchanged.
- R10: A request of kind 0 (shared read) gives event 0, ack_cnt_o of 0 and an empty inv_mask_o.
- R11: sharer_cnt_o is the population count of sharers_o. While req_valid_i is 0, inv_mask_o, ack_cnt_o and wb_ack_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 3 | 0 shared read, 1 exclusive read, 2 upgrade, 3 writeback, 4 eviction |
| req_id_i | input | ID_W | Requesting L1 |
| upd_op_i | input | 3 | 0 none, 1 add, 2 remove, 3 clear, 4 mark exclusive |
| upd_id_i | input | ID_W | L1 the update refers to |
| evt_valid_o | output | 1 | Classification valid |
| evt_o | output | 3 | Event class, 0 to 5 as in the requirements |
| inv_mask_o | output | N_L1 | Invalidation destinations |
| ack_cnt_o | output | ACK_W | Signed acknowledgement count for the reply |
| wb_ack_o | output | 1 | Writeback must be acknowledged |
| sharers_o | output | N_L1 | Current sharer vector |
| owner_o | output | ID_W | Current exclusive owner |
| sharer_cnt_o | output | CNT_W | Number of sharers |

## Verification
The checker evaluates several properties on every cycle. It confirms that an upgrade event only appears for a sharer, that the invalidation mask is a subset of the sharers and never names the requester for exclusive reads or upgrades, and that shared reads carry a zero count. It also checks the upgrade count against the sharer population and that mark-exclusive and clear land in the following cycle. Other behaviour only shows up in the bench's scenarios, which compare against a model of the vector. These include the exact exclusive-read count with and without the requester in the set, the stale-writeback path, the full-vector eviction mask, and add or remove sequences that build up the vector.

// File: rtl/sharer_ack_pkg.sv
package sharer_ack_pkg;
   typedef enum logic [2:0] {
      K_RD_SH  = 3'd0,
      K_RD_EX  = 3'd1,
      K_UPG    = 3'd2,
      K_WB     = 3'd3,
      K_EVICT  = 3'd4
   } req_kind_e;

   typedef enum logic [2:0] {
      E_READ     = 3'd0,
      E_READX    = 3'd1,
      E_UPGRADE  = 3'd2,
      E_WB       = 3'd3,
      E_WB_STALE = 3'd4,
      E_EVICT    = 3'd5
   } evt_e;

   typedef enum logic [2:0] {
      U_NONE  = 3'd0,
      U_ADD   = 3'd1,
      U_DEL   = 3'd2,
      U_CLEAR = 3'd3,
      U_MARK  = 3'd4
   } upd_op_e;
endpackage

// File: rtl/sharer_ack_onehot.sv
module sharer_ack_onehot #(
   parameter int N    = 8,
   parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [ID_W-1:0] id_i,
   output logic [N-1:0]    oh_o
);
   for (genvar i = 0; i < N; i++) begin : g_dec
      assign oh_o[i] = (id_i == ID_W'(i));
   end
endmodule

// File: rtl/sharer_ack_popcount.sv
module sharer_ack_popcount #(
   parameter int N     = 8,
   parameter int CNT_W = $clog2(N + 1)
) (
   input  logic [N-1:0]     vec_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] acc [N+1];
   assign acc[0] = '0;
   for (genvar i = 0; i < N; i++) begin : g_acc
      assign acc[i+1] = acc[i] + CNT_W'(vec_i[i]);
   end
   assign cnt_o = acc[N];
endmodule

// File: rtl/sharer_ack_classify.sv
module sharer_ack_classify
   import sharer_ack_pkg::*;
#(
   parameter int N_L1  = 8,
   parameter int CNT_W = $clog2(N_L1 + 1),
   parameter int ACK_W = CNT_W + 1
) (
   input  logic                    valid_i,
   input  logic [2:0]              kind_i,
   input  logic [N_L1-1:0]         req_oh_i,
   input  logic [N_L1-1:0]         sharers_i,
   input  logic [CNT_W-1:0]        cnt_i,
   output logic [2:0]              evt_o,
   output logic [N_L1-1:0]         inv_mask_o,
   output logic signed [ACK_W-1:0] ack_o,
   output logic                    wb_ack_o
);
   logic                    is_sh;
   logic [N_L1-1:0]         others;
   logic signed [ACK_W-1:0] neg_cnt;

   assign is_sh   = |(sharers_i & req_oh_i);
   assign others  = sharers_i & ~req_oh_i;
   assign neg_cnt = ACK_W'(0) - ACK_W'(cnt_i);

   always_comb begin
      evt_o      = E_READ;
      inv_mask_o = '0;
      ack_o      = '0;
      wb_ack_o   = 1'b0;
      if (valid_i) begin
         case (kind_i)
            K_RD_EX: begin
               evt_o      = E_READX;
               inv_mask_o = others;
               ack_o      = neg_cnt + ACK_W'(is_sh);
            end
            K_UPG: begin
               inv_mask_o = others;
               if (is_sh) begin
                  evt_o = E_UPGRADE;
                  ack_o = neg_cnt + ACK_W'(1);
               end else begin
                  evt_o = E_READX;
                  ack_o = neg_cnt;
               end
            end
            K_WB: begin
               evt_o    = is_sh ? E_WB : E_WB_STALE;
               wb_ack_o = 1'b1;
            end
            K_EVICT: begin
               evt_o      = E_EVICT;
               inv_mask_o = sharers_i;
            end
            default: evt_o = E_READ;
         endcase
      end
   end
endmodule

// File: rtl/sharer_ack_unit.sv
module sharer_ack_unit
   import sharer_ack_pkg::*;
#(
   parameter int N_L1  = 8,
   parameter int ID_W  = (N_L1 > 1) ? $clog2(N_L1) : 1,
   parameter int CNT_W = $clog2(N_L1 + 1),
   parameter int ACK_W = CNT_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid_i,
   input  logic [2:0]              req_kind_i,
   input  logic [ID_W-1:0]         req_id_i,
   input  logic [2:0]              upd_op_i,
   input  logic [ID_W-1:0]         upd_id_i,
   output logic                    evt_valid_o,
   output logic [2:0]              evt_o,
   output logic [N_L1-1:0]         inv_mask_o,
   output logic signed [ACK_W-1:0] ack_cnt_o,
   output logic                    wb_ack_o,
   output logic [N_L1-1:0]         sharers_o,
   output logic [ID_W-1:0]         owner_o,
   output logic [CNT_W-1:0]        sharer_cnt_o
);
   if (N_L1 < 2 || N_L1 > 64) begin : g_bad_n
      $error("sharer_ack_unit: N_L1 must lie in 2..64");
   end
   if (ACK_W < CNT_W + 1) begin : g_bad_ack
      $error("sharer_ack_unit: ACK_W too narrow for negated count");
   end

   logic [N_L1-1:0] sh_q;
   logic [ID_W-1:0] own_q;
   logic [N_L1-1:0] req_oh, upd_oh;

   sharer_ack_onehot #(.N(N_L1), .ID_W(ID_W)) u_req_dec (.id_i(req_id_i), .oh_o(req_oh));
   sharer_ack_onehot #(.N(N_L1), .ID_W(ID_W)) u_upd_dec (.id_i(upd_id_i), .oh_o(upd_oh));

   sharer_ack_popcount #(.N(N_L1), .CNT_W(CNT_W)) u_pop (.vec_i(sh_q), .cnt_o(sharer_cnt_o));

   sharer_ack_classify #(.N_L1(N_L1), .CNT_W(CNT_W), .ACK_W(ACK_W)) u_cls (
      .valid_i   (req_valid_i),
      .kind_i    (req_kind_i),
      .req_oh_i  (req_oh),
      .sharers_i (sh_q),
      .cnt_i     (sharer_cnt_o),
      .evt_o     (evt_o),
      .inv_mask_o(inv_mask_o),
      .ack_o     (ack_cnt_o),
      .wb_ack_o  (wb_ack_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         own_q <= '0;
      end else begin
         case (upd_op_i)
            U_ADD:   sh_q <= sh_q | upd_oh;
            U_DEL:   sh_q <= sh_q & ~upd_oh;
            U_CLEAR: sh_q <= '0;
            U_MARK: begin
               sh_q  <= upd_oh;
               own_q <= upd_id_i;
            end
            default: ;
         endcase
      end
   end

   assign evt_valid_o = req_valid_i;
   assign sharers_o   = sh_q;
   assign owner_o     = own_q;
endmodule

// File: rtl/sharer_ack_checker.sv
module sharer_ack_checker #(
   parameter int N_L1  = 8,
   parameter int ID_W  = (N_L1 > 1) ? $clog2(N_L1) : 1,
   parameter int CNT_W = $clog2(N_L1 + 1),
   parameter int ACK_W = CNT_W + 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid_i,
   input logic [2:0]              req_kind_i,
   input logic [ID_W-1:0]         req_id_i,
   input logic [2:0]              upd_op_i,
   input logic [ID_W-1:0]         upd_id_i,
   input logic [2:0]              evt_o,
   input logic [N_L1-1:0]         inv_mask_o,
   input logic signed [ACK_W-1:0] ack_cnt_o,
   input logic [N_L1-1:0]         sharers_o,
   input logic [ID_W-1:0]         owner_o
);
   logic live;
   always_ff @(posedge clk) live <= rst_n;

   p_upg_is_sharer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && evt_o == 3'd2) |-> sharers_o[req_id_i]);

   p_inv_no_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && (evt_o == 3'd1 || evt_o == 3'd2)) |-> !inv_mask_o[req_id_i]);

   p_inv_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_mask_o & ~sharers_o) == '0);

   p_upg_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && evt_o == 3'd2) |->
         (int'(ack_cnt_o) == 1 - $countones(sharers_o)));

   p_read_ack_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_kind_i == 3'd0) |-> (ack_cnt_o == '0 && inv_mask_o == '0));

   p_mark_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (live && upd_op_i == 3'd4) |=>
         ($onehot0(sharers_o) && sharers_o[$past(upd_id_i)] && owner_o == $past(upd_id_i)));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (live && upd_op_i == 3'd3) |=> (sharers_o == '0));
endmodule

bind sharer_ack_unit sharer_ack_checker #(
   .N_L1(N_L1), .ID_W(ID_W), .CNT_W(CNT_W), .ACK_W(ACK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
   .req_id_i(req_id_i), .upd_op_i(upd_op_i), .upd_id_i(upd_id_i), .evt_o(evt_o),
   .inv_mask_o(inv_mask_o), .ack_cnt_o(ack_cnt_o), .sharers_o(sharers_o),
   .owner_o(owner_o)
);

// File: tb/sharer_ack_unit_test.sv
module sharer_ack_unit_test;
   localparam int N     = 8;
   localparam int ID_W  = $clog2(N);
   localparam int CNT_W = $clog2(N + 1);
   localparam int ACK_W = CNT_W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid_i = 1'b0;
   logic [2:0] req_kind_i = '0;
   logic [ID_W-1:0] req_id_i = '0;
   logic [2:0] upd_op_i = '0;
   logic [ID_W-1:0] upd_id_i = '0;
   logic evt_valid_o, wb_ack_o;
   logic [2:0] evt_o;
   logic [N-1:0] inv_mask_o, sharers_o;
   logic signed [ACK_W-1:0] ack_cnt_o;
   logic [ID_W-1:0] owner_o;
   logic [CNT_W-1:0] sharer_cnt_o;

   int checks = 0;
   int failures = 0;
   logic [N-1:0] m_sh = '0;
   int m_own = 0;

   always #2.5 clk = ~clk;

   sharer_ack_unit #(.N_L1(N)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
      .req_id_i(req_id_i), .upd_op_i(upd_op_i), .upd_id_i(upd_id_i),
      .evt_valid_o(evt_valid_o), .evt_o(evt_o), .inv_mask_o(inv_mask_o),
      .ack_cnt_o(ack_cnt_o), .wb_ack_o(wb_ack_o), .sharers_o(sharers_o),
      .owner_o(owner_o), .sharer_cnt_o(sharer_cnt_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pop(input logic [N-1:0] v);
      int c = 0;
      for (int i = 0; i < N; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic int exp_evt(input int k, input int id);
      logic s = m_sh[id];
      case (k)
         1: return 1;
         2: return s ? 2 : 1;
         3: return s ? 3 : 4;
         4: return 5;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_ack(input int k, input int id);
      logic s = m_sh[id];
      case (k)
         1: return -pop(m_sh) + int'(s);
         2: return s ? 1 - pop(m_sh) : -pop(m_sh);
         default: return 0;
      endcase
   endfunction

   function automatic int exp_mask(input int k, input int id);
      logic [N-1:0] o = m_sh;
      o[id] = 1'b0;
      case (k)
         1, 2: return int'(o);
         4: return int'(m_sh);
         default: return 0;
      endcase
   endfunction

   task automatic update(input int op, input int id);
      @(negedge clk);
      upd_op_i = 3'(op);
      upd_id_i = ID_W'(id);
      @(negedge clk);
      upd_op_i = '0;
      case (op)
         1: m_sh[id] = 1'b1;
         2: m_sh[id] = 1'b0;
         3: m_sh = '0;
         4: begin m_sh = '0; m_sh[id] = 1'b1; m_own = id; end
         default: ;
      endcase
      check("R9 sharers after update", int'(sharers_o), int'(m_sh));
      check("R8 owner after update", int'(owner_o), m_own);
      check("R11 count", int'(sharer_cnt_o), pop(m_sh));
   endtask

   task automatic request(input int k, input int id, input string tag);
      @(negedge clk);
      req_valid_i = 1'b1;
      req_kind_i = 3'(k);
      req_id_i = ID_W'(id);
      #1;
      check({tag, " evt"}, int'(evt_o), exp_evt(k, id));
      check({tag, " ack"}, int'(ack_cnt_o), exp_ack(k, id));
      check({tag, " mask"}, int'(inv_mask_o), exp_mask(k, id));
      check("R3 wb_ack", int'(wb_ack_o), (k == 3) ? 1 : 0);
      req_valid_i = 1'b0;
      #0.5;
      check("R11 idle outputs", int'(inv_mask_o) + int'(ack_cnt_o) + int'(wb_ack_o), 0);
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset sharers", int'(sharers_o), 0);
      check("R1 reset owner", int'(owner_o), 0);
      check("R1 reset count", int'(sharer_cnt_o), 0);

      // directed corner cases
      request(2, 3, "R2 upgrade from non-sharer, empty set");
      update(1, 3); update(1, 5); update(1, 0);
      request(2, 3, "R2 R5 R6 upgrade from sharer");
      request(2, 6, "R2 upgrade from non-sharer");
      request(1, 5, "R4 R6 readx by sharer");
      request(1, 7, "R4 readx by non-sharer");
      request(3, 0, "R3 writeback by sharer");
      request(3, 4, "R3 stale writeback");
      request(4, 2, "R7 eviction");
      request(0, 5, "R10 shared read");
      update(2, 5);
      request(1, 5, "R4 readx after remove");
      update(4, 6);
      request(2, 6, "R8 R5 upgrade by lone owner");
      update(0, 2);
      update(3, 0);
      request(4, 1, "R7 eviction on empty set");
      for (int i = 0; i < N; i++) update(1, i);
      request(1, 0, "R4 readx full set");
      request(2, N - 1, "R5 upgrade full set");

      // constrained random
      for (int it = 0; it < 400; it++) begin
         int op = int'($urandom_range(0, 4));
         if (op == 3 && ($urandom_range(0, 3) != 0)) op = 1;
         update(op, int'($urandom_range(0, N - 1)));
         request(int'($urandom_range(0, 4)), int'($urandom_range(0, N - 1)), "R2-random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule